// File: doc/BRIEF.md
# Indirect Register Access Port

This block is the host side of a bus controller that shows the processor only two byte-wide locations. One is the address/status location: a host write to it chooses an internal register number, and a host read of it returns an auxiliary status byte at once. No register selection is needed for that read, and the read does not move the selection. The other location is the data window. It reads or writes whichever of the 27 internal byte registers the pointer selects. After each access through the window the pointer moves to the next register, so the host can stream a multi-byte field such as the 24-bit transfer count with one address write followed by several data accesses.

The protocol engine sits behind the block. It reports busy and command-in-progress conditions, parity and buffer-ready flags, and completion events. Each completion event loads the status register and raises the interrupt line. The block guards the register array while the engine is working. It passes accepted commands to the engine as a one-cycle strobe. A command that arrives at the wrong time is discarded and recorded in a flag.

Top module: `irp_port`

## Requirements
- R1: A host write to the address location (port_sel_i=0) loads the pointer from wdata_i[4:0]. A host read of that location returns the auxiliary status byte and leaves the pointer unchanged.
- R2: The auxiliary status byte is laid out as follows: bit 7 interrupt pending, bit 6 last command ignored, bit 5 busy_i, bit 4 cip_i, bits 3:2 always zero, bit 1 perr_i, bit 0 dbr_i.
- R3: With busy_i low, a data-window write to an ordinary register (any number 0..26 except 24 and 25) stores the byte, and a read returns it in the same cycle. Either access then advances the pointer by one, and the pointer wraps from 26 to 0.
- R4: Data-window accesses never advance the pointer while it selects register 24 (command) or register 25 (data). Register 25 is a plain read/write byte.
- R5: xfer_cnt_o is {reg18, reg19, reg20}. Selecting 18 and then making three data writes loads the high, middle and low bytes in that order, and the count reaches 24'hFFFFFF when all three bytes are FF.
- R6: While busy_i is high, a data-window access to an ordinary register has no effect. Writes do not store, reads return 8'h00, the pointer does not move, and a read of register 23 does not clear the interrupt.
- R7: A command write (pointer at 24) while busy_i or cip_i is high is discarded. It produces no strobe and sets the last-command-ignored flag. While cip_i is high, a read of register 24 returns 8'h00.
- R8: A command write while busy_i and cip_i are both low stores the byte in register 24 and drives cmd_code_o with it, with bits 6:0 as the opcode and bit 7 as the single-byte qualifier. cmd_strobe_o is high for exactly the following cycle, and the write clears the last-command-ignored flag.
- R9: An int_set_i pulse loads register 23 with stat_i and sets the interrupt pending flag, which drives irq_o. A data-window read of register 23 that R6 does not block clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R10: A pointer value of 27..31 makes a data-window access do nothing, and a read at such a value returns 8'h00.
- R11: After reset the pointer is 0, all registers and flags are 0, and cmd_strobe_o is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| port_sel_i | input | 1 | 0 selects the address/status location, 1 selects the data window |
| wr_i | input | 1 | Host write strobe |
| rd_i | input | 1 | Host read strobe |
| wdata_i | input | 8 | Host write byte |
| rdata_o | output | 8 | Host read byte (combinational) |
| busy_i | input | 1 | Engine busy |
| cip_i | input | 1 | Engine command in progress |
| perr_i | input | 1 | Parity error flag from the engine |
| dbr_i | input | 1 | Data buffer ready flag from the engine |
| int_set_i | input | 1 | Engine completion event |
| stat_i | input | 8 | Completion status loaded into register 23 |
| irq_o | output | 1 | Interrupt pending |
| cmd_strobe_o | output | 1 | One-cycle pulse after an accepted command |
| cmd_code_o | output | 8 | Contents of the command register |
| xfer_cnt_o | output | 24 | Transfer count {reg18, reg19, reg20} |

## Verification
The bench first streams writes and reads through the window from mid-array pointer values. These runs separate correct auto-increment from a fixed pointer, and the run that crosses register 26 shows the wrap. It then holds the pointer on registers 24 and 25 with repeated accesses, which exposes any increment on those two addresses. Ordinary, command and status accesses are repeated with busy_i and cip_i at each combination, which tells gated accesses apart from accepted ones and shows the ignored-command flag setting and clearing. Interrupt set, clear and simultaneous set-and-clear patterns, together with out-of-range pointers, finish the run.

// File: rtl/irp_pkg.sv
package irp_pkg;
  typedef enum logic [1:0] {
    SLOT_PLAIN,
    SLOT_CMD,
    SLOT_DATA,
    SLOT_VOID
  } slot_e;

  localparam int AUX_INT  = 7;
  localparam int AUX_LCI  = 6;
  localparam int AUX_BSY  = 5;
  localparam int AUX_CIP  = 4;
  localparam int AUX_PERR = 1;
  localparam int AUX_DBR  = 0;
endpackage

// File: rtl/irp_gate.sv
module irp_gate
  import irp_pkg::*;
#(
  parameter int NREG     = 27,
  parameter int AW       = 5,
  parameter int CMD_IDX  = 24,
  parameter int DATA_IDX = 25
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          addr_wr_i,
  input  logic [AW-1:0] addr_i,
  input  logic          dat_acc_i,
  input  logic          busy_i,
  input  logic          cip_i,
  output logic [AW-1:0] ptr_o,
  output slot_e         slot_o,
  output logic          plain_open_o,
  output logic          cmd_rd_open_o,
  output logic          cmd_wr_ok_o
);
  localparam logic [AW-1:0] LAST = AW'(NREG - 1);

  logic [AW-1:0] ptr_q;

  always_comb begin
    if (ptr_q > LAST)                 slot_o = SLOT_VOID;
    else if (ptr_q == AW'(CMD_IDX))   slot_o = SLOT_CMD;
    else if (ptr_q == AW'(DATA_IDX))  slot_o = SLOT_DATA;
    else                              slot_o = SLOT_PLAIN;
  end

  assign plain_open_o  = (slot_o == SLOT_PLAIN) && !busy_i;
  assign cmd_rd_open_o = (slot_o == SLOT_CMD) && !cip_i;
  assign cmd_wr_ok_o   = !busy_i && !cip_i;
  assign ptr_o         = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                          ptr_q <= '0;
    else if (addr_wr_i)                   ptr_q <= addr_i;
    else if (dat_acc_i && plain_open_o)   ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
  end

  assert_ptr_hold_cmd_data_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_acc_i && !addr_wr_i && (ptr_q == AW'(CMD_IDX) || ptr_q == AW'(DATA_IDX)))
      |=> (ptr_q == $past(ptr_q)));

  assert_busy_ptr_frozen_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_acc_i && !addr_wr_i && busy_i) |=> $stable(ptr_q));

  assert_void_ptr_frozen_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_acc_i && !addr_wr_i && ptr_q > LAST) |=> $stable(ptr_q));
endmodule

// File: rtl/irp_regfile.sv
module irp_regfile #(
  parameter int NREG     = 27,
  parameter int DW       = 8,
  parameter int AW       = 5,
  parameter int STAT_IDX = 23,
  parameter int CMD_IDX  = 24,
  parameter int CNT_IDX  = 18,
  parameter int CNT_LEN  = 3
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  we_i,
  input  logic [AW-1:0]         idx_i,
  input  logic [DW-1:0]         wdata_i,
  input  logic                  eng_we_i,
  input  logic [DW-1:0]         eng_data_i,
  output logic [DW-1:0]         rdata_o,
  output logic [DW-1:0]         cmd_o,
  output logic [CNT_LEN*DW-1:0] cnt_o
);
  logic [DW-1:0] regs_q [NREG];

  for (genvar i = 0; i < NREG; i++) begin : g_reg
    if (i == STAT_IDX) begin : g_stat
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            regs_q[i] <= '0;
        else if (eng_we_i)                      regs_q[i] <= eng_data_i;
        else if (we_i && idx_i == AW'(i))       regs_q[i] <= wdata_i;
      end
    end else begin : g_plain
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)                            regs_q[i] <= '0;
        else if (we_i && idx_i == AW'(i))       regs_q[i] <= wdata_i;
      end
    end
  end

  // high byte sits at the lowest register number
  for (genvar k = 0; k < CNT_LEN; k++) begin : g_cnt
    assign cnt_o[(CNT_LEN-1-k)*DW +: DW] = regs_q[CNT_IDX + k];
  end

  assign cmd_o   = regs_q[CMD_IDX];
  assign rdata_o = (idx_i < AW'(NREG)) ? regs_q[idx_i] : '0;
endmodule

// File: rtl/irp_aux.sv
module irp_aux
  import irp_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       int_set_i,
  input  logic       int_clr_i,
  input  logic       cmd_try_i,
  input  logic       cmd_ok_i,
  input  logic       busy_i,
  input  logic       cip_i,
  input  logic       perr_i,
  input  logic       dbr_i,
  output logic [7:0] aux_o,
  output logic       irq_o
);
  logic int_q, lci_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      int_q <= 1'b0;
      lci_q <= 1'b0;
    end else begin
      if (int_set_i)      int_q <= 1'b1;
      else if (int_clr_i) int_q <= 1'b0;
      if (cmd_ok_i)       lci_q <= 1'b0;
      else if (cmd_try_i) lci_q <= 1'b1;
    end
  end

  always_comb begin
    aux_o           = '0;
    aux_o[AUX_INT]  = int_q;
    aux_o[AUX_LCI]  = lci_q;
    aux_o[AUX_BSY]  = busy_i;
    aux_o[AUX_CIP]  = cip_i;
    aux_o[AUX_PERR] = perr_i;
    aux_o[AUX_DBR]  = dbr_i;
  end

  assign irq_o = int_q;

  assert_lci_on_busy_cmd_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_try_i && (busy_i || cip_i)) |=> lci_q);

  assert_int_set_wins_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int_set_i |=> irq_o);

  assert_int_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (int_clr_i && !int_set_i) |=> !irq_o);
endmodule

// File: rtl/irp_port.sv
module irp_port
  import irp_pkg::*;
#(
  parameter int NREG     = 27,
  parameter int DW       = 8,
  parameter int CNT_LEN  = 3,
  parameter int CNT_IDX  = 18,
  parameter int STAT_IDX = 23,
  parameter int CMD_IDX  = 24,
  parameter int DATA_IDX = 25,
  localparam int AW      = $clog2(NREG + 1),
  localparam int CW      = CNT_LEN * DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          port_sel_i,
  input  logic          wr_i,
  input  logic          rd_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  input  logic          busy_i,
  input  logic          cip_i,
  input  logic          perr_i,
  input  logic          dbr_i,
  input  logic          int_set_i,
  input  logic [DW-1:0] stat_i,
  output logic          irq_o,
  output logic          cmd_strobe_o,
  output logic [DW-1:0] cmd_code_o,
  output logic [CW-1:0] xfer_cnt_o
);
  logic          addr_wr, dat_wr, dat_rd, dat_acc;
  logic [AW-1:0] ptr;
  slot_e         slot;
  logic          plain_open, cmd_rd_open, cmd_wr_ok;
  logic          cmd_try, cmd_ok, reg_we, int_clr, rd_open;
  logic [DW-1:0] reg_rdata;
  logic [7:0]    aux;
  logic          strobe_q;

  assign addr_wr = !port_sel_i && wr_i;
  assign dat_wr  = port_sel_i && wr_i;
  assign dat_rd  = port_sel_i && rd_i && !wr_i;
  assign dat_acc = port_sel_i && (wr_i || rd_i);

  irp_gate #(.NREG(NREG), .AW(AW), .CMD_IDX(CMD_IDX), .DATA_IDX(DATA_IDX)) u_gate (
    .clk_i, .rst_ni,
    .addr_wr_i    (addr_wr),
    .addr_i       (wdata_i[AW-1:0]),
    .dat_acc_i    (dat_acc),
    .busy_i, .cip_i,
    .ptr_o        (ptr),
    .slot_o       (slot),
    .plain_open_o (plain_open),
    .cmd_rd_open_o(cmd_rd_open),
    .cmd_wr_ok_o  (cmd_wr_ok)
  );

  assign cmd_try = dat_wr && (slot == SLOT_CMD);
  assign cmd_ok  = cmd_try && cmd_wr_ok;
  assign reg_we  = (dat_wr && (plain_open || slot == SLOT_DATA)) || cmd_ok;
  assign int_clr = dat_rd && plain_open && (ptr == AW'(STAT_IDX));
  assign rd_open = plain_open || (slot == SLOT_DATA) || cmd_rd_open;

  irp_regfile #(.NREG(NREG), .DW(DW), .AW(AW), .STAT_IDX(STAT_IDX), .CMD_IDX(CMD_IDX),
                .CNT_IDX(CNT_IDX), .CNT_LEN(CNT_LEN)) u_regs (
    .clk_i, .rst_ni,
    .we_i      (reg_we),
    .idx_i     (ptr),
    .wdata_i,
    .eng_we_i  (int_set_i),
    .eng_data_i(stat_i),
    .rdata_o   (reg_rdata),
    .cmd_o     (cmd_code_o),
    .cnt_o     (xfer_cnt_o)
  );

  irp_aux u_aux (
    .clk_i, .rst_ni,
    .int_set_i, .int_clr_i(int_clr),
    .cmd_try_i(cmd_try), .cmd_ok_i(cmd_ok),
    .busy_i, .cip_i, .perr_i, .dbr_i,
    .aux_o(aux), .irq_o
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) strobe_q <= 1'b0;
    else         strobe_q <= cmd_ok;
  end

  assign cmd_strobe_o = strobe_q;
  assign rdata_o      = !port_sel_i ? DW'(aux) : (rd_open ? reg_rdata : '0);

  assert_strobe_carries_code_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_strobe_o |-> (cmd_code_o == $past(wdata_i)));

  assert_no_strobe_when_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dat_wr && (slot == SLOT_CMD) && (busy_i || cip_i)) |=> !cmd_strobe_o);
endmodule

// File: tb/tb_irp_port.sv
`timescale 1ns/1ps
module tb_irp_port;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sel = 0, wr = 0, rd = 0, busy = 0, cip = 0, perr = 0, dbr = 0, iset = 0;
  logic [7:0] wd = 0, stat = 0;
  logic [7:0] rdata, code;
  logic irq, strobe;
  logic [23:0] cnt;

  int n_cmp = 0, n_bad = 0;

  // reference state
  logic [7:0] m_regs [0:26];
  int   m_ptr;
  bit   m_int, m_lci, m_strobe;

  always #2.5 clk = ~clk;

  irp_port dut (
    .clk_i(clk), .rst_ni(rst_n), .port_sel_i(sel), .wr_i(wr), .rd_i(rd), .wdata_i(wd),
    .rdata_o(rdata), .busy_i(busy), .cip_i(cip), .perr_i(perr), .dbr_i(dbr),
    .int_set_i(iset), .stat_i(stat), .irq_o(irq), .cmd_strobe_o(strobe),
    .cmd_code_o(code), .xfer_cnt_o(cnt)
  );

  task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_rdata();
    if (!sel) return {m_int, m_lci, busy, cip, 2'b00, perr, dbr};
    if (m_ptr > 26) return 8'h00;
    if (m_ptr == 24) return cip ? 8'h00 : m_regs[24];
    if (m_ptr == 25) return m_regs[25];
    if (busy) return 8'h00;
    return m_regs[m_ptr];
  endfunction

  task automatic model_step();
    bit nstrobe = 0;
    if (wr && !sel) m_ptr = int'(wd[4:0]);
    else if (sel && (wr || rd)) begin
      if (m_ptr <= 26) begin
        if (m_ptr == 24) begin
          if (wr) begin
            if (busy || cip) m_lci = 1;
            else begin m_regs[24] = wd; nstrobe = 1; m_lci = 0; end
          end
        end else if (m_ptr == 25) begin
          if (wr) m_regs[25] = wd;
        end else if (!busy) begin
          if (wr) m_regs[m_ptr] = wd;
          else if (m_ptr == 23) m_int = 0;
          m_ptr = (m_ptr == 26) ? 0 : m_ptr + 1;
        end
      end
    end
    if (iset) begin m_regs[23] = stat; m_int = 1; end
    m_strobe = nstrobe;
  endtask

  // one bus cycle: inputs are set at the negedge, outputs compared before the posedge
  task automatic cyc(string tag, bit s, bit w, bit r, logic [7:0] d);
    sel = s; wr = w; rd = r; wd = d;
    #1;
    chk(tag, "rdata", 32'(rdata), 32'(exp_rdata()));
    chk(tag, "irq", 32'(irq), 32'(m_int));
    chk(tag, "strobe", 32'(strobe), 32'(m_strobe));
    chk(tag, "code", 32'(code), 32'(m_regs[24]));
    chk(tag, "cnt", 32'(cnt), {8'h0, m_regs[18], m_regs[19], m_regs[20]});
    @(posedge clk);
    model_step();
    @(negedge clk);
    sel = 0; wr = 0; rd = 0; iset = 0;
  endtask

  task automatic aw(string tag, logic [7:0] a);  cyc(tag, 0, 1, 0, a); endtask
  task automatic dw(string tag, logic [7:0] d);  cyc(tag, 1, 1, 0, d); endtask
  task automatic dr(string tag);                 cyc(tag, 1, 0, 1, 8'h00); endtask
  task automatic ar(string tag);                 cyc(tag, 0, 0, 1, 8'h00); endtask
  task automatic idle(string tag);               cyc(tag, 0, 0, 0, 8'h00); endtask

  initial begin
    #(200000 * 5);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < 27; i++) m_regs[i] = 8'h00;
    m_ptr = 0; m_int = 0; m_lci = 0; m_strobe = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R11 reset state
    ar("R11"); dr("R11"); ar("R11");

    // R1/R3 streaming from a mid-array pointer
    aw("R1", 8'd3);
    dw("R3", 8'h11); dw("R3", 8'h22); dw("R3", 8'h33);
    ar("R1"); aw("R1", 8'd3);
    dr("R3"); dr("R3"); dr("R3"); ar("R1");

    // R2 aux layout with flags driven
    perr = 1; ar("R2"); dbr = 1; ar("R2"); busy = 1; ar("R2");
    busy = 0; cip = 1; ar("R2"); cip = 0; perr = 0; dbr = 0; ar("R2");

    // R5 transfer count
    aw("R5", 8'd18); dw("R5", 8'hAB); dw("R5", 8'hCD); dw("R5", 8'hEF); idle("R5");
    aw("R5", 8'd18); dw("R5", 8'hFF); dw("R5", 8'hFF); dw("R5", 8'hFF); idle("R5");

    // R3 wrap from 26 to 0
    aw("R3", 8'd26); dw("R3", 8'h5A); dw("R3", 8'h77); aw("R3", 8'd26); dr("R3"); dr("R3");

    // R4 data register keeps the pointer
    aw("R4", 8'd25); dw("R4", 8'h01); dw("R4", 8'h02); dr("R4"); dr("R4"); dw("R4", 8'hC3); dr("R4");

    // R8 accepted command
    aw("R8", 8'd24); dw("R8", 8'h95); idle("R8"); dr("R4"); dr("R4"); dw("R8", 8'h20); dw("R8", 8'hA0); idle("R8");

    // R6 busy lockout on ordinary registers
    aw("R6", 8'd5); busy = 1; dw("R6", 8'h99); dr("R6"); dr("R6");
    busy = 0; dr("R6"); dr("R6");

    // R7 commands while busy / cip, then R8 clears the flag
    aw("R7", 8'd24); busy = 1; dw("R7", 8'h07); ar("R7"); idle("R7");
    busy = 0; cip = 1; dw("R7", 8'h08); dr("R7"); ar("R7");
    cip = 0; dr("R7"); dw("R8", 8'h09); ar("R8"); idle("R8");

    // R9 interrupt set, read clear, simultaneous set and clear
    stat = 8'h42; iset = 1; idle("R9"); ar("R9");
    aw("R9", 8'd23); busy = 1; dr("R9"); busy = 0; ar("R9");
    dr("R9"); ar("R9");
    aw("R9", 8'd23); stat = 8'h81; iset = 1; dr("R9"); ar("R9");
    aw("R9", 8'd23); dr("R9"); ar("R9");

    // R10 out-of-range pointer
    aw("R10", 8'd30); dw("R10", 8'hEE); dr("R10"); ar("R10");
    aw("R10", 8'd27); dr("R10"); dw("R10", 8'h12); dr("R10");
    aw("R10", 8'd0); dr("R10");

    idle("R11");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule